// File: doc/BRIEF.md
# Floating-point status and exception control register

This block is the single status/control word of a floating-point coprocessor. Software reads and writes it as a 32-bit word. The execution unit reports each completed operation through an update strobe. With that strobe it gives the sign and zero state of the result, the outcome of a compare, and the exception events the operation raised.

The register keeps three kinds of bits:

- **Condition bits** describe only the most recent operation and are rewritten by every update.
- **Sticky exception flags** collect events over many operations. Only software or reset clears them.
- **Mask bits** are set by software. Each one lets its sticky flag raise an exception request.

The block also tracks faults on result write-back. A fault is recorded only when software has enabled it. While a fault is recorded, the next restart command does not re-execute the operation. The block instead signals that the restart completes by storing the previously faulted result.

The current rounding mode is presented continuously to the arithmetic datapath. The exception request is a registered output.

Top module: `fpu_status_reg`

## Requirements
- R1: Bits 23:22 hold the rounding mode, and `round_mode` always shows them. The encodings are 00 nearest, 01 toward plus infinity, 10 toward minus infinity and 11 toward zero. Only a software write changes them.
- R2: On every cycle with `upd_valid` high and no software write, bit 21 takes `upd_neg` and bit 20 takes `upd_zero`. Without an update, both hold their value.
- R3: Bit 19 (conversion overflow) is set by an update with `upd_cvt_ovf` high. It stays set until reset or a software write.
- R4: The sticky flags are bit 18 (inexact), bit 9 (invalid), bit 8 (overflow), bit 7 (underflow) and bit 6 (divide by zero). Each one is ORed with its event on every update and is never cleared by an update. Only reset or a software write clears them.
- R5: Every update sets bit 17 (instruction-executed flag).
- R6: An update with `upd_is_cmp` high loads bit 16 with `upd_unord`. An update that is not a compare leaves bit 16 unchanged.
- R7: Bit 0 is a software-only enable. A `wr_fault` pulse sets bit 15 on the next edge only when bit 0 is 1. With bit 0 at 0, the pulse has no effect.
- R8: While `restart` is high, the two restart outputs decode bit 15 in the same cycle:
  - With bit 15 at 0, `restart_reexec` is 1 and `restart_store` is 0.
  - With bit 15 at 1, `restart_store` is 1 (done, store the faulted result) and `restart_reexec` is 0. Bit 15 then clears on the edge, unless a new enabled fault arrives in that same cycle.
  - Both outputs are 0 while `restart` is low.
- R9: `exc_req` is a register. Its value is the OR of five mask/sticky pairs, taken from the register contents of the previous cycle. The pairs are 14/9, 13/8, 12/7, 11/6 and 10/18.
- R10: A software write in the same cycle as an update, a fault or a restart wins for every bit. The next read returns `sw_wdata` with the unimplemented bits forced to zero.
- R11: Bits 31:24 and 5:1 always read 0, and writing ones to them has no effect.
- R12: After reset, every register bit and `exc_req` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Current register contents |
| upd_valid | input | 1 | Operation-complete strobe from the execution unit |
| upd_neg | input | 1 | Result was negative |
| upd_zero | input | 1 | Result was zero |
| upd_is_cmp | input | 1 | Operation was a compare |
| upd_unord | input | 1 | Compare was unordered |
| upd_cvt_ovf | input | 1 | Float-to-integer conversion overflowed |
| upd_inexact | input | 1 | Inexact event |
| upd_invalid | input | 1 | Invalid-operation event |
| upd_ovf | input | 1 | Overflow event |
| upd_unf | input | 1 | Underflow event |
| upd_dz | input | 1 | Divide-by-zero event |
| wr_fault | input | 1 | Fault while writing a result to memory |
| restart | input | 1 | Restart command |
| round_mode | output | 2 | Current rounding mode |
| exc_req | output | 1 | Exception request |
| restart_reexec | output | 1 | Restart re-executes the operation |
| restart_store | output | 1 | Restart completes by storing the faulted result |

## Verification
The hardest state to reach is a recorded write fault that meets a restart. Reaching it takes three steps in order: software first sets the enable bit, then a fault pulse arrives, and finally a restart is issued. The restart may also coincide with a fresh fault, or with a software write that overrides both. The stimulus walks these orderings explicitly. It then runs a long pseudo-random phase in which enable writes, faults, restarts and updates overlap freely. That phase also lands same-cycle write/update collisions and mask/sticky pairs that switch the exception request on and off.

// File: rtl/fpu_status_reg.sv
module fpu_status_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_we,
  input  logic [31:0] sw_wdata,
  output logic [31:0] sw_rdata,
  input  logic        upd_valid,
  input  logic        upd_neg,
  input  logic        upd_zero,
  input  logic        upd_is_cmp,
  input  logic        upd_unord,
  input  logic        upd_cvt_ovf,
  input  logic        upd_inexact,
  input  logic        upd_invalid,
  input  logic        upd_ovf,
  input  logic        upd_unf,
  input  logic        upd_dz,
  input  logic        wr_fault,
  input  logic        restart,
  output logic [1:0]  round_mode,
  output logic        exc_req,
  output logic        restart_reexec,
  output logic        restart_store
);
  logic [1:0] rm_q;
  logic       neg_q, zero_q, cvt_q, inx_q, ctx_q, unord_q, wf_q;
  logic [4:0] mask_q;
  logic       inv_q, ovf_q, unf_q, dz_q, wfen_q;
  logic [4:0] sticky;
  logic       wf_set, wf_clr;

  assign sticky = {inv_q, ovf_q, unf_q, dz_q, inx_q};
  assign wf_set = wr_fault & wfen_q;
  assign wf_clr = restart & wf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rm_q <= 2'b00; neg_q <= 1'b0; zero_q <= 1'b0; cvt_q <= 1'b0;
      inx_q <= 1'b0; ctx_q <= 1'b0; unord_q <= 1'b0; wf_q <= 1'b0;
      mask_q <= 5'd0; inv_q <= 1'b0; ovf_q <= 1'b0; unf_q <= 1'b0;
      dz_q <= 1'b0; wfen_q <= 1'b0;
    end else if (sw_we) begin
      rm_q    <= sw_wdata[23:22];
      neg_q   <= sw_wdata[21];
      zero_q  <= sw_wdata[20];
      cvt_q   <= sw_wdata[19];
      inx_q   <= sw_wdata[18];
      ctx_q   <= sw_wdata[17];
      unord_q <= sw_wdata[16];
      wf_q    <= sw_wdata[15];
      mask_q  <= sw_wdata[14:10];
      inv_q   <= sw_wdata[9];
      ovf_q   <= sw_wdata[8];
      unf_q   <= sw_wdata[7];
      dz_q    <= sw_wdata[6];
      wfen_q  <= sw_wdata[0];
    end else begin
      if (upd_valid) begin
        neg_q  <= upd_neg;
        zero_q <= upd_zero;
        cvt_q  <= cvt_q | upd_cvt_ovf;
        inx_q  <= inx_q | upd_inexact;
        inv_q  <= inv_q | upd_invalid;
        ovf_q  <= ovf_q | upd_ovf;
        unf_q  <= unf_q | upd_unf;
        dz_q   <= dz_q  | upd_dz;
        ctx_q  <= 1'b1;
        if (upd_is_cmp) unord_q <= upd_unord;
      end
      if (wf_set)      wf_q <= 1'b1;
      else if (wf_clr) wf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exc_req <= 1'b0;
    else        exc_req <= |(mask_q & sticky);
  end

  assign sw_rdata = {8'd0, rm_q, neg_q, zero_q, cvt_q, inx_q, ctx_q, unord_q,
                     wf_q, mask_q, inv_q, ovf_q, unf_q, dz_q, 5'd0, wfen_q};
  assign round_mode     = rm_q;
  assign restart_reexec = restart & ~wf_q;
  assign restart_store  = restart & wf_q;
endmodule

module fpu_status_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sw_we,
  input logic [31:0] sw_wdata,
  input logic [31:0] sw_rdata,
  input logic        upd_valid,
  input logic        wr_fault,
  input logic        restart,
  input logic        exc_req,
  input logic        restart_reexec,
  input logic        restart_store
);
  localparam logic [31:0] IMPL   = 32'h00FF_FFC1;
  localparam logic [31:0] STICKY = 32'h0004_03C0;

  a_r8_restart_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(restart_reexec && restart_store));
  a_r8_restart_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> !(restart_reexec || restart_store));
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> sw_rdata == ($past(sw_wdata) & IMPL));
  a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we |=> ((sw_rdata & STICKY) & $past(sw_rdata & STICKY)) == $past(sw_rdata & STICKY));
  a_r5_ctx_set: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !sw_we) |=> sw_rdata[17]);
  a_r7_fault_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && !sw_rdata[0] && !sw_rdata[15]) |=> !sw_rdata[15]);
  a_r9_exc_timing: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> exc_req == $past(|({sw_rdata[14:10]} & {sw_rdata[9:6], sw_rdata[18]})));
  a_r11_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rdata & ~IMPL) == 32'd0);
  a_r7_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && wr_fault && sw_rdata[0]) |=> sw_rdata[15]);
endmodule

bind fpu_status_reg fpu_status_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
  .upd_valid(upd_valid), .wr_fault(wr_fault), .restart(restart), .exc_req(exc_req),
  .restart_reexec(restart_reexec), .restart_store(restart_store)
);

// File: tb/tb_fpu_status_reg.sv
module tb_fpu_status_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_we = 1'b0;
  logic [31:0] sw_wdata = 32'd0;
  logic [31:0] sw_rdata;
  logic upd_valid = 1'b0, upd_neg = 1'b0, upd_zero = 1'b0, upd_is_cmp = 1'b0;
  logic upd_unord = 1'b0, upd_cvt_ovf = 1'b0, upd_inexact = 1'b0, upd_invalid = 1'b0;
  logic upd_ovf = 1'b0, upd_unf = 1'b0, upd_dz = 1'b0, wr_fault = 1'b0, restart = 1'b0;
  logic [1:0] round_mode;
  logic exc_req, restart_reexec, restart_store;

  always #10 clk = ~clk;

  fpu_status_reg dut (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .upd_valid(upd_valid), .upd_neg(upd_neg), .upd_zero(upd_zero), .upd_is_cmp(upd_is_cmp),
    .upd_unord(upd_unord), .upd_cvt_ovf(upd_cvt_ovf), .upd_inexact(upd_inexact),
    .upd_invalid(upd_invalid), .upd_ovf(upd_ovf), .upd_unf(upd_unf), .upd_dz(upd_dz),
    .wr_fault(wr_fault), .restart(restart), .round_mode(round_mode), .exc_req(exc_req),
    .restart_reexec(restart_reexec), .restart_store(restart_store)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [31:0] m = 32'd0;
  logic exp_exc = 1'b0;
  bit prev_we = 0;
  logic [31:0] prev_wd = 32'd0;
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 round mode", {30'd0, round_mode}, {30'd0, m[23:22]});
    chk("R1 round bits", {30'd0, sw_rdata[23:22]}, {30'd0, m[23:22]});
    chk("R2 neg/zero", {30'd0, sw_rdata[21:20]}, {30'd0, m[21:20]});
    chk("R3 conversion overflow", {31'd0, sw_rdata[19]}, {31'd0, m[19]});
    chk("R4 sticky flags", sw_rdata & 32'h0004_03C0, m & 32'h0004_03C0);
    chk("R5 executed flag", {31'd0, sw_rdata[17]}, {31'd0, m[17]});
    chk("R6 unordered", {31'd0, sw_rdata[16]}, {31'd0, m[16]});
    chk("R7 fault/enable", {30'd0, sw_rdata[15], sw_rdata[0]}, {30'd0, m[15], m[0]});
    chk("R9 exception request", {31'd0, exc_req}, {31'd0, exp_exc});
    chk("R8 restart decode", {30'd0, restart_reexec, restart_store},
        {30'd0, restart & ~m[15], restart & m[15]});
    chk("R11 unimplemented bits", sw_rdata & 32'hFF00_003E, 32'd0);
    if (prev_we) chk("R10 write word", sw_rdata, prev_wd & 32'h00FF_FFC1);
  endtask

  task automatic model_edge();
    logic [31:0] n;
    exp_exc = |(m[14:10] & {m[9:6], m[18]});
    n = m;
    if (sw_we) n = sw_wdata & 32'h00FF_FFC1;
    else begin
      if (upd_valid) begin
        n[21] = upd_neg; n[20] = upd_zero;
        n[19] = m[19] | upd_cvt_ovf; n[18] = m[18] | upd_inexact;
        n[9] = m[9] | upd_invalid; n[8] = m[8] | upd_ovf;
        n[7] = m[7] | upd_unf; n[6] = m[6] | upd_dz;
        n[17] = 1'b1;
        if (upd_is_cmp) n[16] = upd_unord;
      end
      if (wr_fault && m[0]) n[15] = 1'b1;
      else if (restart && m[15]) n[15] = 1'b0;
    end
    prev_we = sw_we;
    prev_wd = sw_wdata;
    m = n;
  endtask

  task automatic clear_in();
    sw_we = 0; sw_wdata = 0; upd_valid = 0; upd_neg = 0; upd_zero = 0; upd_is_cmp = 0;
    upd_unord = 0; upd_cvt_ovf = 0; upd_inexact = 0; upd_invalid = 0; upd_ovf = 0;
    upd_unf = 0; upd_dz = 0; wr_fault = 0; restart = 0;
  endtask

  task automatic step();
    #1;
    compare_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    clear_in();
  endtask

  task automatic wr(input logic [31:0] d);
    sw_we = 1; sw_wdata = d; step();
  endtask

  task automatic upd(input logic [10:0] f);
    upd_valid = 1;
    {upd_neg, upd_zero, upd_is_cmp, upd_unord, upd_cvt_ovf, upd_inexact,
     upd_invalid, upd_ovf, upd_unf, upd_dz} = f[9:0];
    step();
  endtask

  initial begin
    #200000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 reset word", sw_rdata, 32'd0);
    chk("R12 reset exc", {31'd0, exc_req}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    step();
    // R1: each rounding encoding
    wr(32'h0040_0000); wr(32'h0080_0000); wr(32'h00C0_0000); wr(32'h0000_0000);
    // R11: ones to every bit
    wr(32'hFFFF_FFFF); step(); wr(32'h0);
    // R2/R5: condition overwrite
    upd(11'b01_0000_0000_0 >> 1); upd(11'b00_1000_0000_0 >> 1); upd(11'd0); step();
    // R6: compare unordered, then non-compare, then ordered compare
    upd(11'b0011_000000); upd(11'd0); step(); upd(11'b0010_000000); step();
    // R3/R4: accumulate events
    upd(11'b0000_100000); upd(11'b0000_010000); upd(11'b0000_001000);
    upd(11'b0000_000100); upd(11'b0000_000010); upd(11'b0000_000001); upd(11'd0); step();
    // R9: masks on one at a time
    wr(32'h0000_4200); step(); step();
    wr(32'h0000_0100); step(); wr(32'h0000_2000); step(); step();
    wr(32'h0004_0400); step(); step();
    wr(32'h0000_0000); step(); step();
    // R7: fault with enable off, then on
    wr_fault = 1; step(); step();
    wr(32'h0000_0001); wr_fault = 1; step(); step();
    // R8: restart with fault pending, then without
    restart = 1; step(); restart = 1; step(); step();
    // R8: fault and restart same cycle keeps fault
    wr_fault = 1; step(); wr_fault = 1; restart = 1; step(); restart = 1; step();
    // R10: write collides with update, fault and restart
    wr_fault = 1; step();
    sw_we = 1; sw_wdata = 32'h0012_3400; upd_valid = 1; upd_neg = 1; upd_inexact = 1;
    wr_fault = 1; restart = 1; step(); step();
    // random mix
    wr(32'h0000_0001);
    for (int i = 0; i < 1500; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      upd_valid = lfsr[0]; upd_neg = lfsr[1]; upd_zero = lfsr[2]; upd_is_cmp = lfsr[3];
      upd_unord = lfsr[4]; upd_cvt_ovf = &lfsr[6:5]; upd_inexact = &lfsr[8:7];
      upd_invalid = &lfsr[10:9]; upd_ovf = &lfsr[12:11]; upd_unf = &lfsr[14:13];
      upd_dz = &lfsr[16:15]; wr_fault = &lfsr[19:17]; restart = &lfsr[21:20];
      sw_we = &lfsr[25:22];
      sw_wdata = {lfsr[31:16] ^ lfsr[15:0], lfsr[15:0]};
      step();
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule